// File: doc/BRIEF.md
# Quadtree Compressed-Block Locator

This block finds one 64-bit compressed texture block that is stored in a sparse quadtree. The caller gives a block coordinate pair (in units of 4x4 texel blocks), a mip level and the texture width in blocks. The texture is taken to be square. The block then walks the tree in a word-addressed node memory until it reaches a leaf. It returns the two words that the leaf points at as one 64-bit block. The block does not decode the compressed block, and it does not write any cache.

Each node is a 32-bit word. Bit 31 set means the node is a leaf. A leaf carries a block address in bits 30:0. A non-leaf node carries the index of the first of its four children in bits 30:0. The root node of each mip level sits at the memory index equal to that level. At every descent step the walker compares each coordinate with half of the current span and subtracts that half where the coordinate reaches it. It then moves to one of the four children and halves the span.

The memory port is a plain read port. Read data is valid in the cycle after the read request. The caller uses a start/busy/done handshake.

Top module: `qtl_block_locator`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `err` and `mem_rd_en` are 0 and `blk_data` is all zeros.
- R2: The first memory read after an accepted start goes to index `mip`, which is the root node of that level.
- R3: A node word with bit 31 = 1 is a leaf whose bits 30:0 are a block address. With bit 31 = 0, bits 30:0 are the index of the first of four consecutive child words.
- R4: The span starts at `tex_w >> mip`. At each step, h = span/2. A coordinate >= h has h subtracted from it. The child taken is base + 2*(y >= h) + (x >= h). The span then becomes h.
- R5: At a leaf with address A, the low 32 bits of `blk_data` come from word A and the high 32 bits come from word A+1. The two reads are issued in back-to-back cycles.
- R6: `busy` rises in the cycle after a start is accepted while idle. `done` is a single-cycle pulse with `busy` low. A `start` seen while busy is ignored.
- R7: `blk_data` and `err` keep their values from one `done` until the next accepted start. The next accepted start clears `err`. `blk_data` changes only when a new result is written.
- R8: At most floor(log2(tex_w))+1 descents are allowed. A leaf reached on exactly that step is returned normally. A non-leaf node reached after that many descents ends the walk with `err` = 1 and `done`, and `blk_data` is left unchanged.
- R9: A successful walk with d descents raises `done` exactly 6 + 2*d clock edges after the edge that accepts start, counting that edge.
- R10: The mip level selects both the root word and the starting span. The same coordinates therefore reach different leaves at different levels, and a level of the same width reached from a wider texture walks the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a lookup; taken only while idle |
| blk_x | input | COORD_W | Block column within the mip level |
| blk_y | input | COORD_W | Block row within the mip level |
| mip | input | MIP_W | Mip level; also the root node index |
| tex_w | input | COORD_W+1 | Texture width in blocks at level 0 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Depth limit exceeded on the last walk |
| blk_data | output | 64 | Assembled compressed block |
| mem_rd_en | output | 1 | Node memory read request |
| mem_addr | output | MEM_AW | Node memory word index |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |

## Verification
The bench goes after the quadrant selection at every depth. It uses coordinates that sit exactly on the half-span boundary, such as x = 4 in an 8-wide level. A design that compares with > instead of >=, or that swaps the x and y weights, would return a neighbouring leaf's block. It checks that the walk takes a leaf on the last allowed step but stops with an error one step later, so an off-by-one limit would either fail a legal walk or return garbage. It also checks the word order of the assembled block, a start pulse issued in the middle of a walk, and that `blk_data` is untouched by an error. It checks the exact completion cycle against the depth, which catches an extra or missing pipeline stage.

// File: rtl/qtl_pkg.sv
package qtl_pkg;

    localparam int NODE_W  = 32;
    localparam int BLOCK_W = 2 * NODE_W;
    localparam int PTR_W   = NODE_W - 1;

    // Node word: top bit flags a leaf, remaining bits point somewhere.
    typedef struct packed {
        logic             leaf;
        logic [PTR_W-1:0] ptr;
    } node_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_NODE = 3'd1,
        ST_EVAL    = 3'd2,
        ST_RD_LO   = 3'd3,
        ST_GET_LO  = 3'd4,
        ST_GET_HI  = 3'd5
    } walk_st_t;

    // Index of the highest set bit (0 for an input of zero).
    function automatic int unsigned floor_log2(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/qtl_quad_step.sv
module qtl_quad_step #(
    parameter int COORD_W = 12,
    parameter int WID_W   = COORD_W + 1
) (
    input  logic [COORD_W-1:0] x_in,
    input  logic [COORD_W-1:0] y_in,
    input  logic [WID_W-1:0]   half,
    output logic [COORD_W-1:0] x_out,
    output logic [COORD_W-1:0] y_out,
    output logic [1:0]         quad
);

    localparam int EXT_W = WID_W - COORD_W;

    logic [COORD_W-1:0] c_in  [2];
    logic [COORD_W-1:0] c_out [2];
    logic [1:0]         upper;

    assign c_in[0] = x_in;
    assign c_in[1] = y_in;

    // One compare-and-subtract lane per axis.
    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic [WID_W-1:0] ext;
        assign ext      = {{EXT_W{1'b0}}, c_in[a]};
        assign upper[a] = (ext >= half);
        assign c_out[a] = upper[a] ? COORD_W'(ext - half) : c_in[a];
    end

    assign x_out = c_out[0];
    assign y_out = c_out[1];
    // Child order: y weight 2, x weight 1.
    assign quad  = {upper[1], upper[0]};

endmodule

// File: rtl/qtl_depth_limit.sv
module qtl_depth_limit
    import qtl_pkg::*;
#(
    parameter int WID_W = 13,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WID_W-1:0] tex_w,
    input  logic             step,
    output logic             at_cap
);

    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            cap_q <= CNT_W'(floor_log2(32'(tex_w)) + 1);
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_cap = (cnt_q == cap_q);

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= cap_q); // R8

    AST_NO_STEP_AT_CAP: assert property (@(posedge clk) disable iff (rst)
        at_cap && !load |-> !step); // R8

endmodule

// File: rtl/qtl_block_assembler.sv
module qtl_block_assembler
    import qtl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_lo,
    input  logic               cap_hi,
    input  logic [NODE_W-1:0]  word,
    output logic [BLOCK_W-1:0] data_o
);

    logic [NODE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            data_o <= '0;
        end else begin
            if (cap_lo) lo_q <= word;
            if (cap_hi) data_o <= {word, lo_q};
        end
    end

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
        cap_hi |-> $past(cap_lo)); // R5

endmodule

// File: rtl/qtl_block_locator.sv
module qtl_block_locator
    import qtl_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int MIP_W   = 4,
    parameter int MEM_AW  = 31
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [COORD_W-1:0]   blk_x,
    input  logic [COORD_W-1:0]   blk_y,
    input  logic [MIP_W-1:0]     mip,
    input  logic [COORD_W:0]     tex_w,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [BLOCK_W-1:0]   blk_data,
    output logic                 mem_rd_en,
    output logic [MEM_AW-1:0]    mem_addr,
    input  logic [NODE_W-1:0]    mem_rdata
);

    localparam int WID_W = COORD_W + 1;
    localparam int CNT_W = $clog2(WID_W + 2);

    walk_st_t           state_q;
    logic [MEM_AW-1:0]  ptr_q;
    logic [COORD_W-1:0] x_q, y_q;
    logic [WID_W-1:0]   span_q;
    logic               done_q, err_q;

    node_t              node;
    logic [COORD_W-1:0] nx, ny;
    logic [1:0]         quad;
    logic               accept, descend, at_cap;
    logic               cap_lo, cap_hi;

    assign node    = node_t'(mem_rdata);
    assign accept  = (state_q == ST_IDLE) && start;
    assign descend = (state_q == ST_EVAL) && !node.leaf && !at_cap;
    assign cap_lo  = (state_q == ST_GET_LO);
    assign cap_hi  = (state_q == ST_GET_HI);

    qtl_quad_step #(
        .COORD_W (COORD_W),
        .WID_W   (WID_W)
    ) u_quad (
        .x_in  (x_q),
        .y_in  (y_q),
        .half  (span_q >> 1),
        .x_out (nx),
        .y_out (ny),
        .quad  (quad)
    );

    qtl_depth_limit #(
        .WID_W (WID_W),
        .CNT_W (CNT_W)
    ) u_depth (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .tex_w  (tex_w),
        .step   (descend),
        .at_cap (at_cap)
    );

    qtl_block_assembler u_asm (
        .clk    (clk),
        .rst    (rst),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi),
        .word   (mem_rdata),
        .data_o (blk_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            x_q     <= '0;
            y_q     <= '0;
            span_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        x_q     <= blk_x;
                        y_q     <= blk_y;
                        ptr_q   <= MEM_AW'(mip);
                        span_q  <= tex_w >> mip;
                        err_q   <= 1'b0;
                        state_q <= ST_RD_NODE;
                    end
                end
                ST_RD_NODE: state_q <= ST_EVAL;
                ST_EVAL: begin
                    if (node.leaf) begin
                        ptr_q   <= node.ptr[MEM_AW-1:0];
                        state_q <= ST_RD_LO;
                    end else if (at_cap) begin
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        ptr_q   <= node.ptr[MEM_AW-1:0] + MEM_AW'(quad);
                        x_q     <= nx;
                        y_q     <= ny;
                        span_q  <= span_q >> 1;
                        state_q <= ST_RD_NODE;
                    end
                end
                ST_RD_LO:  state_q <= ST_GET_LO;
                ST_GET_LO: state_q <= ST_GET_HI;
                ST_GET_HI: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign mem_rd_en = (state_q == ST_RD_NODE) || (state_q == ST_RD_LO)
                    || (state_q == ST_GET_LO);
    assign mem_addr  = (state_q == ST_GET_LO) ? ptr_q + 1'b1 : ptr_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R6

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy); // R6

    AST_ROOT_FIRST: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> mem_rd_en && mem_addr == MEM_AW'($past(mip))); // R2

    AST_PAIR_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en && $past(mem_rd_en) |-> mem_addr == $past(mem_addr) + 1'b1); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(blk_data)); // R7

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done); // R8

endmodule

// File: tb/qtl_block_locator_bench.sv
module qtl_block_locator_bench;

    localparam int COORD_W = 12;
    localparam int MIP_W   = 4;
    localparam int MEM_AW  = 31;
    localparam int NV      = 12;

    // Vector table: x, y, mip, texture width, leaf address, descents.
    localparam int VX [NV] = '{1, 5, 6, 2, 7, 4, 5, 7, 3, 0, 1, 3};
    localparam int VY [NV] = '{2, 1, 7, 6, 0, 3, 2, 3, 1, 3, 0, 1};
    localparam int VM [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2, 1};
    localparam int VW [NV] = '{8, 8, 8, 8, 8, 8, 8, 8, 8, 8, 8, 16};
    localparam int VA [NV] = '{100, 106, 104, 102, 108, 116, 114, 110, 122, 124, 128, 120};
    localparam int VD [NV] = '{1, 2, 1, 1, 2, 3, 3, 2, 1, 1, 0, 1};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic [COORD_W-1:0]   blk_x = '0;
    logic [COORD_W-1:0]   blk_y = '0;
    logic [MIP_W-1:0]     mip = '0;
    logic [COORD_W:0]     tex_w = '0;
    logic                 busy, done, err, mem_rd_en;
    logic [63:0]          blk_data;
    logic [MEM_AW-1:0]    mem_addr;
    logic [31:0]          mem_rdata = '0;
    logic [31:0]          mem [256];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    qtl_block_locator #(
        .COORD_W (COORD_W),
        .MIP_W   (MIP_W),
        .MEM_AW  (MEM_AW)
    ) u_qtl_block_locator (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .blk_x     (blk_x),
        .blk_y     (blk_y),
        .mip       (mip),
        .tex_w     (tex_w),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .blk_data  (blk_data),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [31:0] leaf(input int a);
        return 32'h8000_0000 | 32'(a);
    endfunction

    function automatic logic [31:0] inner(input int b);
        return 32'(b);
    endfunction

    function automatic logic [63:0] expect_blk(input int a);
        return {32'h5A00_0000 | 32'(a + 1), 32'h5A00_0000 | 32'(a)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts a walk and counts edges until done; poke re-pulses start mid-walk.
    task automatic run(input int x, input int y, input int m, input int w,
                       input bit poke, output int cyc);
        @(negedge clk);
        blk_x = COORD_W'(x); blk_y = COORD_W'(y);
        mip = MIP_W'(m); tex_w = (COORD_W+1)'(w);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 300) begin
            if (poke && cyc == 2) begin
                blk_x = 6; blk_y = 7; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [63:0] held;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int i = 100; i < 130; i++) mem[i] = 32'h5A00_0000 | 32'(i);
        // mip 0 tree
        mem[0]  = inner(16);
        mem[16] = leaf(100); mem[17] = inner(20); mem[18] = leaf(102); mem[19] = leaf(104);
        mem[20] = leaf(106); mem[21] = leaf(108); mem[22] = inner(24); mem[23] = leaf(110);
        mem[24] = leaf(112); mem[25] = leaf(114); mem[26] = leaf(116); mem[27] = leaf(118);
        // mip 1 tree
        mem[1]  = inner(28);
        mem[28] = leaf(120); mem[29] = leaf(122); mem[30] = leaf(124); mem[31] = leaf(126);
        // mip 2 root is a leaf
        mem[2]  = leaf(128);
        // mip 3: endless chain of inner nodes
        mem[3]  = inner(32);
        for (int i = 32; i < 36; i++) mem[i] = inner(32);
        // mip 4: leaf reached on exactly the fourth descent
        mem[4]  = inner(36);
        for (int i = 36; i < 40; i++) mem[i] = inner(40);
        for (int i = 40; i < 44; i++) mem[i] = inner(44);
        for (int i = 44; i < 48; i++) mem[i] = inner(48);
        for (int i = 48; i < 52; i++) mem[i] = leaf(126);

        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 rd_en", 64'(mem_rd_en), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 err", 64'(err), 64'd0);
        chk("R1 blk_data", blk_data, 64'd0);

        // R3 R4 R5 R9 R10: table walk
        for (int i = 0; i < NV; i++) begin
            run(VX[i], VY[i], VM[i], VW[i], 1'b0, cyc);
            chk($sformatf("R4 R5 R10 vec%0d data", i), blk_data, expect_blk(VA[i]));
            chk($sformatf("R9 vec%0d cycles", i), 64'(cyc), 64'(6 + 2 * VD[i]));
            chk($sformatf("R3 vec%0d err", i), 64'(err), 64'd0);
        end

        // R2: root read address follows mip
        @(negedge clk);
        blk_x = 0; blk_y = 0; mip = 2; tex_w = 8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 root rd_en", 64'(mem_rd_en), 64'd1);
        chk("R2 root addr", 64'(mem_addr), 64'd2);
        while (!done) @(negedge clk);

        // R6: start during a walk is ignored
        run(1, 2, 0, 8, 1'b1, cyc);
        chk("R6 ignored start data", blk_data, expect_blk(100));
        chk("R6 ignored start cycles", 64'(cyc), 64'd8);
        @(negedge clk);
        chk("R6 done pulse", 64'(done), 64'd0);
        chk("R6 idle", 64'(busy), 64'd0);

        // R7: result held while idle with inputs moving
        held = blk_data;
        blk_x = 7; blk_y = 7; mip = 1; tex_w = 4;
        repeat (5) @(negedge clk);
        chk("R7 hold", blk_data, held);

        // R8: leaf on the last permitted descent
        run(0, 0, 4, 8, 1'b0, cyc);
        chk("R8 edge leaf data", blk_data, expect_blk(126));
        chk("R8 edge leaf err", 64'(err), 64'd0);
        chk("R8 edge leaf cycles", 64'(cyc), 64'd14);

        // R8: one descent too many
        held = blk_data;
        run(0, 0, 3, 8, 1'b0, cyc);
        chk("R8 limit err", 64'(err), 64'd1);
        chk("R8 limit data unchanged", blk_data, held);
        repeat (3) @(negedge clk);
        chk("R7 err held", 64'(err), 64'd1);

        // R7: next start clears err
        run(6, 7, 0, 8, 1'b0, cyc);
        chk("R7 err cleared", 64'(err), 64'd0);
        chk("R7 new data", blk_data, expect_blk(104));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule